// File: doc/BRIEF.md
# Channel Address Compaction Unit

This unit turns a system physical address into the address seen by one memory channel. A signed offset is first added at 64 KiB granularity. Then the unit squeezes out the address bits that channel interleaving used to pick the channel. Up to three single bits can be removed, and an optional divide-by-3 of the cache-line index serves three-way interleave. Upstream logic selects the rule that applies to an address. It presents that rule's settings alongside each address, so every input carries its own configuration.

The unit is fully pipelined. It accepts one address per clock and returns each result a fixed number of cycles later. Results leave in order, flagged by a valid bit. The divide-by-3 is a pipelined constant divider spread over `DIV_STAGES` register stages. Every result takes the same path, whether or not the divide is enabled, so the latency does not depend on the configuration.

Top module: `chan_addr_compact`

## Requirements
- R1: While `rstN` is low, `outValid` is 0. After reset, `outValid` stays 0 until a result is due.
- R2: Each accepted input (`inValid`=1 at a rising edge) yields exactly one result. `outValid` is 1 on the result exactly LAT = DIV_STAGES+1 rising edges later (5 by default). Results come out in input order, and `outValid` is 0 in every other cycle.
- R3: Offset stage. Bits [39:16] of the working value are (inAddr[39:16] + sign-extended inOffset) modulo 2^24. Bits [15:6] are inAddr[15:6]. Bits [5:0] are 0. Address bits above 39 do not affect the result.
- R4: When `inRemove8`=1, bit 8 is dropped. Bits [7:0] are kept, and every bit above 8 moves down one place, with a 0 entering at the top.
- R5: When `inRemove7`=1, bit 7 is dropped in the same way, keeping bits [6:0]. This is applied to the value after the R4 step.
- R6: When `inRemove6`=1, bit 6 is dropped in the same way, keeping bits [5:0]. This is applied after the R5 step.
- R7: After the removals, the value is cut to 37 bits. Bits that were above bit 36 before the removals can therefore reach the result.
- R8: When `inDiv3`=1, result bits [36:6] are replaced by floor(bits[36:6] / 3), and bits [5:0] stay 0. Result bit 36 is then always 0.
- R9: The configuration inputs are sampled together with their address. Back-to-back inputs with different settings each get their own settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Address and settings are presented this cycle |
| inAddr | input | ADDR_W (48) | System physical address |
| inOffset | input | OFS_W (16) | Signed offset in 64 KiB units |
| inRemove8 | input | 1 | Drop address bit 8 |
| inRemove7 | input | 1 | Drop address bit 7 (after bit 8) |
| inRemove6 | input | 1 | Drop address bit 6 (after bit 7) |
| inDiv3 | input | 1 | Divide cache-line index by 3 |
| outValid | output | 1 | `outAddr` holds a result |
| outAddr | output | CH_W (37) | Channel address |

## Verification
A new address can enter the offset-and-removal stage in the same cycle that an older address is still part-way through the divider, or is being emitted. The two may carry opposite divide and removal settings. The bench provokes this with back-to-back streams that alternate `inDiv3` and the removal flags, then with a long random stream that has random gaps. It judges every cycle against a behavioural 64-bit model and a queue of due cycles, so a configuration that leaks from one address to its neighbour shows up as a value mismatch. A stage that slips by a cycle shows up as a missing or unexpected `outValid`.

// File: rtl/cacu_pkg.sv
package cacu_pkg;
  // Upper bound on divider stages carried by the strobe struct.
  localparam int MAX_DIV_STAGES = 8;

  typedef struct packed {
    logic                      frontLoad;  // capture new address in front stage
    logic [MAX_DIV_STAGES-1:0] divLoad;    // per-stage advance of the divider
  } cacu_strobe_t;
endpackage

// File: rtl/cacu_div3_slice.sv
// Combinational slice of a restoring divide-by-3: BPS quotient bits per slice.
module cacu_div3_slice #(
  parameter int BPS = 8
) (
  input  logic [1:0]     remIn,
  input  logic [BPS-1:0] chunk,
  output logic [BPS-1:0] qOut,
  output logic [1:0]     remOut
);
  always_comb begin
    logic [2:0] r;
    r = {1'b0, remIn};
    qOut = '0;
    for (int j = BPS - 1; j >= 0; j--) begin
      r = {r[1:0], chunk[j]};
      if (r >= 3'd3) begin
        qOut[j] = 1'b1;
        r = r - 3'd3;
      end
    end
    remOut = r[1:0];
  end
endmodule

// File: rtl/cacu_ctrl.sv
// Valid pipeline; turns it into load strobes for the datapath.
module cacu_ctrl import cacu_pkg::*; #(
  parameter int DIV_STAGES = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output cacu_strobe_t strobes,
  output logic         outValid
);
  logic [DIV_STAGES:0] validPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validPipe <= '0;
    else       validPipe <= {validPipe[DIV_STAGES-1:0], inValid};
  end

  always_comb begin
    strobes = '0;
    strobes.frontLoad = inValid;
    strobes.divLoad[DIV_STAGES-1:0] = validPipe[DIV_STAGES-1:0];
  end

  assign outValid = validPipe[DIV_STAGES];
endmodule

// File: rtl/cacu_datapath.sv
// Offset add, ordered bit removal, then pipelined divide-by-3.
module cacu_datapath import cacu_pkg::*; #(
  parameter int ADDR_W     = 48,
  parameter int OFS_W      = 16,
  parameter int CH_W       = 37,
  parameter int DIV_STAGES = 4
) (
  input  logic                    clk,
  input  cacu_strobe_t            strobes,
  input  logic [ADDR_W-1:0]       inAddr,
  input  logic signed [OFS_W-1:0] inOffset,
  input  logic                    inRemove8,
  input  logic                    inRemove7,
  input  logic                    inRemove6,
  input  logic                    inDiv3,
  output logic [CH_W-1:0]         outAddr
);
  // Three removals can pull bits from up to 3 places above the kept width.
  localparam int INT_W = CH_W + 3;
  localparam int HI_W  = INT_W - 16;
  localparam int Q_W   = CH_W - 6;
  localparam int BPS   = (Q_W + DIV_STAGES - 1) / DIV_STAGES;
  localparam int PAD_W = BPS * DIV_STAGES;

  function automatic logic [INT_W-1:0] dropBit(input logic [INT_W-1:0] v, input int pos);
    logic [INT_W-1:0] r;
    for (int i = 0; i < INT_W; i++) begin
      if (i < pos)            r[i] = v[i];
      else if (i < INT_W - 1) r[i] = v[i+1];
      else                    r[i] = 1'b0;
    end
    return r;
  endfunction

  // ---------------- front stage: offset + removal ----------------
  logic [HI_W-1:0]  hiSum;
  logic [INT_W-1:0] compact;
  logic [2:0]       dropEn;

  assign hiSum  = inAddr[INT_W-1:16] + {{(HI_W-OFS_W){inOffset[OFS_W-1]}}, inOffset};
  assign dropEn = {inRemove8, inRemove7, inRemove6};

  always_comb begin
    compact = {hiSum, inAddr[15:6], 6'b0};
    // Fixed order 8, 7, 6: each shift moves the bit the next step sees.
    for (int k = 0; k < 3; k++)
      if (dropEn[2-k]) compact = dropBit(compact, 8 - k);
  end

  logic [CH_W-1:0] frontVal;
  logic            frontDiv;

  always_ff @(posedge clk) begin
    if (strobes.frontLoad) begin
      frontVal <= compact[CH_W-1:0];
      frontDiv <= inDiv3;
    end
  end

  // ---------------- divider pipeline ----------------
  logic [CH_W-1:0]  stgVal [DIV_STAGES+1];
  logic             stgDiv [DIV_STAGES+1];
  logic [1:0]       stgRem [DIV_STAGES+1];
  logic [PAD_W-1:0] stgQuo [DIV_STAGES+1];

  assign stgVal[0] = frontVal;
  assign stgDiv[0] = frontDiv;
  assign stgRem[0] = 2'd0;
  assign stgQuo[0] = '0;

  for (genvar s = 0; s < DIV_STAGES; s++) begin : g_stage
    logic [PAD_W-1:0] numPad;
    logic [BPS-1:0]   qOut;
    logic [1:0]       remOut;
    logic [PAD_W-1:0] quoNext;
    logic [CH_W-1:0]  sVal;
    logic             sDiv;
    logic [1:0]       sRem;
    logic [PAD_W-1:0] sQuo;

    assign numPad  = PAD_W'(stgVal[s][CH_W-1:6]);
    assign quoNext = stgQuo[s] | (PAD_W'(qOut) << (PAD_W - BPS - s * BPS));

    cacu_div3_slice #(.BPS(BPS)) u_slice (
      .remIn (stgRem[s]),
      .chunk (numPad[PAD_W-1-s*BPS -: BPS]),
      .qOut  (qOut),
      .remOut(remOut)
    );

    always_ff @(posedge clk) begin
      if (strobes.divLoad[s]) begin
        sVal <= stgVal[s];
        sDiv <= stgDiv[s];
        sRem <= remOut;
        sQuo <= quoNext;
      end
    end

    assign stgVal[s+1] = sVal;
    assign stgDiv[s+1] = sDiv;
    assign stgRem[s+1] = sRem;
    assign stgQuo[s+1] = sQuo;
  end

  assign outAddr = stgDiv[DIV_STAGES] ? {stgQuo[DIV_STAGES][Q_W-1:0], 6'b0}
                                      : stgVal[DIV_STAGES];

  logic unusedBits;
  assign unusedBits = ^{inAddr, strobes.divLoad, stgRem[DIV_STAGES], stgQuo[DIV_STAGES]};
endmodule

// File: rtl/chan_addr_compact.sv
// Top: thin wrapper joining control and datapath.
module chan_addr_compact import cacu_pkg::*; #(
  parameter int ADDR_W     = 48,
  parameter int OFS_W      = 16,
  parameter int CH_W       = 37,
  parameter int DIV_STAGES = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic [ADDR_W-1:0]       inAddr,
  input  logic signed [OFS_W-1:0] inOffset,
  input  logic                    inRemove8,
  input  logic                    inRemove7,
  input  logic                    inRemove6,
  input  logic                    inDiv3,
  output logic                    outValid,
  output logic [CH_W-1:0]         outAddr
);
  cacu_strobe_t strobes;

  cacu_ctrl #(.DIV_STAGES(DIV_STAGES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobes (strobes),
    .outValid(outValid)
  );

  cacu_datapath #(
    .ADDR_W(ADDR_W), .OFS_W(OFS_W), .CH_W(CH_W), .DIV_STAGES(DIV_STAGES)
  ) u_dp (
    .clk      (clk),
    .strobes  (strobes),
    .inAddr   (inAddr),
    .inOffset (inOffset),
    .inRemove8(inRemove8),
    .inRemove7(inRemove7),
    .inRemove6(inRemove6),
    .inDiv3   (inDiv3),
    .outAddr  (outAddr)
  );
endmodule

// File: rtl/cacu_checker.sv
module cacu_checker #(
  parameter int CH_W       = 37,
  parameter int DIV_STAGES = 4
) (
  input logic            clk,
  input logic            rstN,
  input logic            inValid,
  input logic            inDiv3,
  input logic            outValid,
  input logic [CH_W-1:0] outAddr
);
  localparam int LAT = DIV_STAGES + 1;

  logic [LAT-1:0] vTrack;
  logic [LAT-1:0] dTrack;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vTrack <= '0;
      dTrack <= '0;
    end else begin
      vTrack <= {vTrack[LAT-2:0], inValid};
      dTrack <= {dTrack[LAT-2:0], inValid & inDiv3};
    end
  end

  a_r1_idle_in_reset: assert property (@(posedge clk) !rstN |=> !outValid);

  a_r2_fixed_latency: assert property (@(posedge clk) disable iff (!rstN)
    outValid == vTrack[LAT-1]);

  a_r2_known_output: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !$isunknown(outAddr));

  a_r3_line_bits_zero: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> outAddr[5:0] == 6'd0);

  a_r8_div_top_clear: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && dTrack[LAT-1]) |-> !outAddr[CH_W-1]);
endmodule

bind chan_addr_compact cacu_checker #(.CH_W(CH_W), .DIV_STAGES(DIV_STAGES)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inDiv3(inDiv3),
  .outValid(outValid), .outAddr(outAddr)
);

// File: tb/chan_addr_compact_bench.sv
`timescale 1ns/1ps
module chan_addr_compact_bench;
  localparam int ADDR_W = 48, OFS_W = 16, CH_W = 37, DIV_STAGES = 4;
  localparam int LAT = DIV_STAGES + 1;

  logic clk = 1'b0, rstN = 1'b0, inValid = 1'b0;
  logic [ADDR_W-1:0] inAddr = '0;
  logic signed [OFS_W-1:0] inOffset = '0;
  logic inRemove8 = 0, inRemove7 = 0, inRemove6 = 0, inDiv3 = 0;
  logic outValid;
  logic [CH_W-1:0] outAddr;

  chan_addr_compact #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .CH_W(CH_W), .DIV_STAGES(DIV_STAGES))
  u_chan_addr_compact (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inAddr(inAddr), .inOffset(inOffset),
    .inRemove8(inRemove8), .inRemove7(inRemove7), .inRemove6(inRemove6), .inDiv3(inDiv3),
    .outValid(outValid), .outAddr(outAddr)
  );

  always #2 clk = ~clk;  // 250 MHz

  typedef struct { longint unsigned exp; int due; string tag; } exp_t;
  exp_t pend[$];
  int cyc = 0, tests = 0, fails = 0;
  bit done = 0;

  always @(posedge clk) cyc++;

  // Behavioural reference in 64-bit arithmetic.
  function automatic longint unsigned refModel(longint unsigned a, logic signed [15:0] o,
                                               bit r8, bit r7, bit r6, bit d3);
    longint unsigned c;
    c = (((a >> 16) + longint'(o)) << 16) | (a & 64'hffc0);
    if (r8) c = ((c >> 1) & ~64'hff) | (c & 64'hff);
    if (r7) c = ((c >> 1) & ~64'h7f) | (c & 64'h7f);
    if (r6) c = ((c >> 1) & ~64'h3f) | (c & 64'h3f);
    c = c & 64'h1f_ffff_ffff;
    if (d3) c = (((c >> 6) / 3) << 6) | (c & 64'h3f);
    return c;
  endfunction

  always @(negedge clk) begin
    if (rstN && !done) begin
      if (pend.size() > 0 && pend[0].due == cyc) begin
        tests++;
        if (!outValid) begin
          fails++;
          $display("FAIL R2 (%s): outValid=%0b expected 1 at cycle %0d", pend[0].tag, outValid, cyc);
        end else if (outAddr !== pend[0].exp[CH_W-1:0]) begin
          fails++;
          $display("FAIL %s: outAddr=%h expected %h", pend[0].tag, outAddr, pend[0].exp[CH_W-1:0]);
        end
        void'(pend.pop_front());
      end else if (outValid) begin
        tests++; fails++;
        $display("FAIL R2: outValid=1 expected 0 at cycle %0d", cyc);
      end
    end
  end

  task automatic send(longint unsigned a, logic signed [15:0] o, bit r8, bit r7, bit r6,
                      bit d3, string tag);
    exp_t e;
    @(negedge clk);
    inValid = 1; inAddr = a[ADDR_W-1:0]; inOffset = o;
    inRemove8 = r8; inRemove7 = r7; inRemove6 = r6; inDiv3 = d3;
    e.exp = refModel(a & 64'hffff_ffff_ffff, o, r8, r7, r6, d3);
    e.due = cyc + LAT;
    e.tag = tag;
    pend.push_back(e);
  endtask

  task automatic idle(int n);
    @(negedge clk);
    inValid = 0;
    inRemove8 = $urandom; inDiv3 = $urandom; inAddr = {$urandom, $urandom};
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: run did not end, pending=%0d expected 0", pend.size());
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset with active input must keep outValid low
    inValid = 1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      tests++;
      if (outValid !== 1'b0) begin
        fails++;
        $display("FAIL R1: outValid=%0b expected 0 in reset", outValid);
      end
    end
    inValid = 0;
    rstN = 1;
    idle(4);  // R1: monitor flags any valid before data

    // R3: offset stage, positive, negative, wrapping, high bits ignored
    send(64'h12_3456_789A, 16'sd5, 0, 0, 0, 0, "R3");
    send(64'h12_3456_789A, -16'sd3, 0, 0, 0, 0, "R3");
    send(64'h00_0001_0040, -16'sh8000, 0, 0, 0, 0, "R3");
    send(64'hFF00_0000_FFFF, 16'sd0, 0, 0, 0, 0, "R3");
    idle(3);
    // R4 / R5 / R6: removal alone and in order
    send(64'h1F_FFFF_FF00, 16'sd0, 1, 0, 0, 0, "R4");
    send(64'h0A_5A5A_5180, 16'sd1, 1, 0, 0, 0, "R4");
    send(64'h0A_5A5A_51C0, 16'sd0, 1, 1, 0, 0, "R5");
    send(64'h03_0000_00C0, 16'sd0, 0, 1, 0, 0, "R5");
    send(64'h0A_5A5A_51C0, 16'sd0, 1, 1, 1, 0, "R6");
    send(64'h00_0000_0140, 16'sd0, 0, 0, 1, 0, "R6");
    // R7: upper bits pulled into the 37-bit result
    send(64'h00_0001_0000, -16'sd2, 1, 1, 1, 0, "R7");
    send(64'hE0_0000_0000, 16'sd0, 1, 1, 0, 0, "R7");
    idle(2);
    // R8: divide by 3 corners
    send(64'h1F_FFFF_FFC0, 16'sd0, 0, 0, 0, 1, "R8");
    send(64'h00_0000_00C0, 16'sd0, 0, 0, 0, 1, "R8");
    send(64'h00_0000_0080, 16'sd0, 0, 0, 0, 1, "R8");
    send(64'hFF_FFFF_FFFF, -16'sd1, 1, 1, 1, 1, "R8");
    idle(LAT + 1);
    // R9: back-to-back alternating settings
    for (int i = 0; i < 16; i++)
      send(64'h07_7654_3210 + 64'(i) * 64'h1_1040, 16'(i * 37 - 200),
           i[0], i[1], i[2], i[0] ^ i[3], "R9");
    idle(2);
    // R9/R2: random stream with random gaps
    for (int i = 0; i < 400; i++) begin
      send({$urandom, $urandom}, 16'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), "R9");
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
    end
    idle(LAT + 4);
    tests++;
    if (pend.size() != 0) begin
      fails++;
      $display("FAIL R2: %0d results missing, expected 0", pend.size());
    end
    done = 1;
    summary();
    $finish;
  end
endmodule